// File: doc/BRIEF.md
# Double-Rate Capture Register

This register samples a data word on both the rising and the falling transition of one clock. It uses only ordinary single-transition storage, so it fits any library that has no native double-transition cell. One half register updates on the rising transition and the other on the falling transition. Each half stores the incoming word XOR-ed with the current contents of the other half. A combining stage XORs the two halves, so the output always shows the word sampled at the latest transition of either polarity.

The output changes only as a direct result of a clock transition, and only one half changes at each transition. This keeps the XOR output free of glitches and lets it drive a double-rate output or feed logic that needs half-cycle resolution. The data width is a parameter, and every bit works independently of the others.

Top module: `dual_edge_capture`

## Requirements
- R1: While `rst_ni` is low, `data_o` is all zeros, whatever `data_i` and the clock do.
- R2: After a rising transition of `clk_i`, `data_o` equals the value `data_i` had at that transition. The value holds until the next falling transition.
- R3: After a falling transition of `clk_i`, `data_o` equals the value `data_i` had at that transition. The value holds until the next rising transition.
- R4: Each bit of `data_o` follows only the same bit of `data_i`. All-zeros, all-ones, alternating-bit and single-bit patterns are each reproduced exactly.
- R5: The rising-half register changes only on rising transitions and the falling-half register changes only on falling transitions. A change on `data_i` between transitions therefore leaves `data_o` unchanged.
- R6: Asserting `rst_ni` low in the middle of operation clears `data_o` at once, with no clock transition needed. After release, the first transition of either polarity captures `data_i` again.
- R7: When `data_i` holds the same value across several consecutive transitions of both polarities, `data_o` keeps that value and does not fall back to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. Both of its transitions sample the data. |
| rst_ni | input | 1 | Asynchronous reset, active low. Clears both halves. |
| data_i | input | WIDTH | Data word to capture. |
| data_o | output | WIDTH | Word sampled at the latest transition. This is the XOR of the two halves. |

## Verification
The rising-half update and the falling-half update both occur within every clock cycle. They depend on each other through the cross-coupled XOR. The bench changes the data on every half cycle, using words that differ in every bit and words that repeat. It checks the output one nanosecond after each transition, and judges it against the word the bench drove before that transition. This catches any half that ignores its partner, because a repeated word would then read back as zero. A reset asserted in the middle of a cycle is also checked against the next transition, to confirm that capture resumes from a clean, all-zero state.

// File: rtl/dec_pkg.sv
package dec_pkg;

   localparam int unsigned DEC_DEFAULT_WIDTH = 16;

   // Which clock transition a half register follows.
   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_pol_e;

endpackage

// File: rtl/dec_half_reg.sv
module dec_half_reg
   import dec_pkg::*;
#(
   parameter int unsigned WIDTH = DEC_DEFAULT_WIDTH,
   parameter edge_pol_e   POL   = EDGE_RISE
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] data_i,
   input  logic [WIDTH-1:0] peer_i,
   output logic [WIDTH-1:0] state_o
);

   logic [WIDTH-1:0] next_d;
   logic [WIDTH-1:0] state_q;

   if (WIDTH < 1) begin : g_width_check
      $error("dec_half_reg: WIDTH must be at least 1");
   end

   // Encode the incoming word against the partner half.
   assign next_d  = peer_i ^ data_i;
   assign state_o = state_q;

   if (POL == EDGE_RISE) begin : g_rise
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) state_q <= '0;
         else         state_q <= next_d;
      end

      // Copy taken at the opposite transition, used to check that state holds.
      logic [WIDTH-1:0] held_q;
      logic             held_vld_q;
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            held_q     <= '0;
            held_vld_q <= 1'b0;
         end else begin
            held_q     <= state_q;
            held_vld_q <= 1'b1;
         end
      end

      // R5: rising half does not move between a falling and the next rising transition
      p_rise_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         held_vld_q |-> (state_q == held_q));
   end else begin : g_fall
      always_ff @(negedge clk_i or negedge rst_ni) begin
         if (!rst_ni) state_q <= '0;
         else         state_q <= next_d;
      end

      logic [WIDTH-1:0] held_q;
      logic             held_vld_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            held_q     <= '0;
            held_vld_q <= 1'b0;
         end else begin
            held_q     <= state_q;
            held_vld_q <= 1'b1;
         end
      end

      // R5: falling half does not move between a rising and the next falling transition
      p_fall_only_r5: assert property (@(negedge clk_i) disable iff (!rst_ni)
         held_vld_q |-> (state_q == held_q));
   end

endmodule

// File: rtl/dec_combine.sv
module dec_combine
   import dec_pkg::*;
#(
   parameter int unsigned WIDTH = DEC_DEFAULT_WIDTH
) (
   input  logic [WIDTH-1:0] rise_i,
   input  logic [WIDTH-1:0] fall_i,
   output logic [WIDTH-1:0] word_o
);

   if (WIDTH < 1) begin : g_width_check
      $error("dec_combine: WIDTH must be at least 1");
   end

   // One independent two-input XOR per bit (R4).
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign word_o[b] = rise_i[b] ^ fall_i[b];
   end

endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
   import dec_pkg::*;
#(
   parameter int unsigned WIDTH = DEC_DEFAULT_WIDTH
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] data_o
);

   logic [WIDTH-1:0] rise_q;
   logic [WIDTH-1:0] fall_q;

   if (WIDTH < 1) begin : g_width_check
      $error("dual_edge_capture: WIDTH must be at least 1");
   end

   dec_half_reg #(.WIDTH(WIDTH), .POL(EDGE_RISE)) u_rise (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .data_i  (data_i),
      .peer_i  (fall_q),
      .state_o (rise_q)
   );

   dec_half_reg #(.WIDTH(WIDTH), .POL(EDGE_FALL)) u_fall (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .data_i  (data_i),
      .peer_i  (rise_q),
      .state_o (fall_q)
   );

   dec_combine #(.WIDTH(WIDTH)) u_comb (
      .rise_i (rise_q),
      .fall_i (fall_q),
      .word_o (data_o)
   );

   // Samples of the input at each transition, for tracking checks.
   logic [WIDTH-1:0] rise_smp_q, fall_smp_q;
   logic             rise_vld_q, fall_vld_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rise_smp_q <= '0;
         rise_vld_q <= 1'b0;
      end else begin
         rise_smp_q <= data_i;
         rise_vld_q <= 1'b1;
      end
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fall_smp_q <= '0;
         fall_vld_q <= 1'b0;
      end else begin
         fall_smp_q <= data_i;
         fall_vld_q <= 1'b1;
      end
   end

   // R2: across the high phase the output shows the word taken at the rise
   p_rise_track_r2: assert property (@(negedge clk_i) disable iff (!rst_ni)
      rise_vld_q |-> (data_o == rise_smp_q));

   // R3: across the low phase the output shows the word taken at the fall
   p_fall_track_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_vld_q |-> (data_o == fall_smp_q));

endmodule

// File: tb/sim_dual_edge_capture.sv
module sim_dual_edge_capture;

   localparam int unsigned W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 8 ns period, 125 MHz

   dual_edge_capture #(.WIDTH(W)) u0 (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .data_i (din),
      .data_o (dout)
   );

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: data_o=%h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Drive v, wait for the next transition, check 1 ns later.
   // Called 1 ns after a transition, so v is stable well before the next one.
   task automatic edge_step(input logic [W-1:0] v, input string req);
      din = v;
      @(clk);
      #1;
      chk(dout, v, $sformatf("%s (%s)", req, clk ? "rise, R2" : "fall, R3"));
   endtask

   task automatic t_reset_hold();
      din = 16'hA5A5;
      for (int i = 0; i < 3; i++) begin
         @(clk);
         #1;
         chk(dout, '0, "R1 reset holds zero");
         din = ~din;
      end
      @(negedge clk);
      #2;
      rst_n = 1'b1;
      #1;
      chk(dout, '0, "R1 zero after release before any edge");
   endtask

   task automatic t_patterns();
      edge_step(16'h0000, "R4 all zero");
      edge_step(16'hFFFF, "R4 all one");
      edge_step(16'h5555, "R4 alt bits");
      edge_step(16'hAAAA, "R4 alt bits inverted");
      for (int b = 0; b < 6; b++) edge_step(16'h1 << (b * 3), "R4 single bit");
      edge_step(16'h1234, "R2/R3 mixed");
      edge_step(16'hFEDC, "R2/R3 mixed");
   endtask

   task automatic t_mid_phase();
      for (int i = 0; i < 4; i++) begin
         logic [W-1:0] v;
         v = 16'h3C3C ^ (16'h0F0F * i[W-1:0]);
         edge_step(v, "R5 capture");
         #1 din = ~v;
         #1 chk(dout, v, "R5 mid-phase change ignored");
      end
   endtask

   task automatic t_repeat();
      edge_step(16'hBEEF, "R7 first");
      for (int i = 0; i < 4; i++) edge_step(16'hBEEF, "R7 repeated value");
      edge_step(16'h0001, "R7 change");
      edge_step(16'h0001, "R7 repeated value");
   endtask

   task automatic t_mid_reset();
      edge_step(16'hC0DE, "R6 before reset");
      #1 rst_n = 1'b0;
      #1 chk(dout, '0, "R6 async clear without edge");
      din = 16'h7777;
      @(clk);
      #1 chk(dout, '0, "R6 held during reset");
      #1 rst_n = 1'b1;
      #1 chk(dout, '0, "R6 zero after release");
      edge_step(16'h7777, "R6 first capture after release");
      edge_step(16'h7777, "R6 second capture after release");
      edge_step(16'h0F0F, "R6 resumed");
   endtask

   initial begin
      t_reset_hold();
      t_patterns();
      t_mid_phase();
      t_repeat();
      t_mid_reset();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule